// File: doc/BRIEF.md
# Nine-Bit Serial Receive Address Filter

This block sits behind a serial receiver that has already assembled each frame into eight data bits and a ninth bit. For every completed frame it decides whether the frame reaches software. If the frame is accepted, the block latches the byte and the ninth bit and raises a sticky receive flag.

In the two nine-bit modes, software can arm an address-wait control. While it is armed, only a frame whose ninth bit is 1 and whose byte equals the programmed node address is accepted. This lets a node on a shared multidrop line ignore traffic meant for other nodes. Once its own address has arrived, software disarms address-wait to take the data bytes that follow. After the last data byte, it arms address-wait again.

In the two eight-bit modes the filter plays no part. The ninth-bit register then holds the stop bit that the receiver delivers in the ninth position.

Top module: `mp_addr_filter`

## Requirements
- R1: After a synchronous reset, rx_flag, rx_data and rx_bit9 are all 0.
- R2: In a nine-bit mode (mode_sel 2 or 3) with addr_wait_en=1, a frame is accepted when rx_enable=1, rx_flag=0, frame_bit9=1 and frame_data equals node_addr. Acceptance sets rx_flag and latches the byte and the ninth bit.
- R3: In a nine-bit mode with addr_wait_en=1, a frame with frame_bit9=0 is rejected even when its byte equals node_addr. A frame with frame_bit9=1 and a different byte is also rejected.
- R4: In a nine-bit mode with addr_wait_en=0, every frame is accepted when rx_enable=1 and rx_flag=0, whatever its byte and ninth bit.
- R5: With rx_enable=0, no frame is accepted in any mode.
- R6: A rejected frame leaves rx_flag, rx_data and rx_bit9 at their previous values.
- R7: rx_flag stays at 1 until a cycle with flag_clr=1, and reads 0 on the following cycle. A frame accepted in the same cycle as flag_clr wins, and the flag reads 1.
- R8: A frame that arrives while rx_flag=1 is dropped. The byte and the ninth bit stay unchanged.
- R9: In the eight-bit modes (mode_sel 0 or 1), the address filter is bypassed even with addr_wait_en=1. An accepted frame latches frame_bit9 (the stop bit) into rx_bit9.
- R10: Outputs are registered. An accepted frame is visible on rx_flag, rx_data and rx_bit9 in the cycle after the clock edge that samples frame_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Serial mode: 0,1 eight-bit; 2,3 nine-bit |
| addr_wait_en | input | 1 | Arms address-only acceptance in nine-bit modes |
| rx_enable | input | 1 | Receive enable |
| node_addr | input | 8 | Programmed node address |
| frame_valid | input | 1 | One-cycle strobe: a frame is complete |
| frame_data | input | 8 | Received byte, bits 0 to 7 |
| frame_bit9 | input | 1 | Received ninth bit (stop bit in eight-bit modes) |
| flag_clr | input | 1 | Write-zero strobe for the receive flag |
| rx_flag | output | 1 | Sticky receive flag |
| rx_data | output | 8 | Latched byte |
| rx_bit9 | output | 1 | Latched ninth bit |

## Verification
A wrong accept decision appears on rx_flag in the cycle after the frame strobe. A wrongly latched byte or ninth bit appears on rx_data or rx_bit9 in that same cycle. A flag that does not stick, or fails to clear, shows one cycle after the clear strobe or the dropped frame. A register overwritten by a rejected frame stays wrong until the next accepted frame, so the bench compares all three outputs after every strobe.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT    = 2'd0,
    MODE_8BIT     = 2'd1,
    MODE_9BIT_FIX = 2'd2,
    MODE_9BIT_VAR = 2'd3
  } mpf_mode_e;

  function automatic logic is_nine_bit(input logic [1:0] m);
    return (mpf_mode_e'(m) == MODE_9BIT_FIX) || (mpf_mode_e'(m) == MODE_9BIT_VAR);
  endfunction
endpackage

// File: rtl/mpf_addr_match.sv
module mpf_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] own_addr,
  output logic              hit
);
  logic [DATA_W-1:0] diff;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign diff[gi] = rx_byte[gi] ^ own_addr[gi];
    end
  endgenerate

  assign hit = ~|diff;
endmodule

// File: rtl/mpf_accept.sv
module mpf_accept
  import mpf_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       wait_addr,
  input  logic       enable,
  input  logic       busy,
  input  logic       strobe,
  input  logic       bit9,
  input  logic       addr_hit,
  output logic       take
);
  logic nine;
  logic filter_ok;

  always_comb begin
    nine = is_nine_bit(mode);
    if (!nine || !wait_addr) filter_ok = 1'b1;
    else                     filter_ok = bit9 & addr_hit;
    take = strobe & enable & ~busy & filter_ok;
  end
endmodule

// File: rtl/mpf_rx_hold.sv
module mpf_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_bit9,
  output logic              flag,
  output logic [DATA_W-1:0] byte_q,
  output logic              bit9_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      byte_q <= '0;
      bit9_q <= 1'b0;
    end else begin
      if (take) begin
        flag   <= 1'b1;
        byte_q <= in_byte;
        bit9_q <= in_bit9;
      end else if (clr) begin
        flag   <= 1'b0;
      end
    end
  end

  // R6: no take, registers hold
  a_r6_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(byte_q) && $stable(bit9_q));
  // R7: flag sticky without clear
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag);
  // R10: latched values appear the next cycle
  a_r10_latch_next: assert property (@(posedge clk) disable iff (rst)
    take |=> flag && byte_q == $past(in_byte) && bit9_q == $past(in_bit9));
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              addr_wait_en,
  input  logic              rx_enable,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              frame_valid,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_bit9,
  input  logic              flag_clr,
  output logic              rx_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9
);
  logic addr_hit;
  logic take;

  mpf_addr_match #(.DATA_W(DATA_W)) u_match (
    .rx_byte (frame_data),
    .own_addr(node_addr),
    .hit     (addr_hit)
  );

  mpf_accept u_accept (
    .mode     (mode_sel),
    .wait_addr(addr_wait_en),
    .enable   (rx_enable),
    .busy     (rx_flag),
    .strobe   (frame_valid),
    .bit9     (frame_bit9),
    .addr_hit (addr_hit),
    .take     (take)
  );

  mpf_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .clr    (flag_clr),
    .in_byte(frame_data),
    .in_bit9(frame_bit9),
    .flag   (rx_flag),
    .byte_q (rx_data),
    .bit9_q (rx_bit9)
  );

  // R5: disabled receiver never raises the flag
  a_r5_no_rx_disabled: assert property (@(posedge clk) disable iff (rst)
    !rx_enable && !rx_flag |=> !rx_flag);
  // R3: data frame blocked while waiting for address
  a_r3_data_blocked: assert property (@(posedge clk) disable iff (rst)
    is_nine_bit(mode_sel) && addr_wait_en && frame_valid && !frame_bit9 && !rx_flag |=> !rx_flag);
  // R2: own address accepted
  a_r2_own_addr: assert property (@(posedge clk) disable iff (rst)
    is_nine_bit(mode_sel) && addr_wait_en && rx_enable && frame_valid && frame_bit9 &&
    frame_data == node_addr && !rx_flag |=> rx_flag && rx_bit9 && rx_data == $past(node_addr));
  // R8: frame while flag set is dropped
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    rx_flag && frame_valid |=> $stable(rx_data) && $stable(rx_bit9));
  // R7: clear without frame empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !frame_valid |=> !rx_flag);
endmodule

// File: tb/test_mp_addr_filter.sv
module test_mp_addr_filter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'd2;
  logic         addr_wait_en = 1'b0;
  logic         rx_enable = 1'b0;
  logic [W-1:0] node_addr = '0;
  logic         frame_valid = 1'b0;
  logic [W-1:0] frame_data = '0;
  logic         frame_bit9 = 1'b0;
  logic         flag_clr = 1'b0;
  logic         rx_flag;
  logic [W-1:0] rx_data;
  logic         rx_bit9;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic         m_flag = 1'b0;
  logic [W-1:0] m_data = '0;
  logic         m_bit9 = 1'b0;

  always #4 clk = ~clk;

  mp_addr_filter #(.DATA_W(W)) i_mp_addr_filter (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr_wait_en(addr_wait_en),
    .rx_enable(rx_enable), .node_addr(node_addr), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_bit9(frame_bit9), .flag_clr(flag_clr),
    .rx_flag(rx_flag), .rx_data(rx_data), .rx_bit9(rx_bit9)
  );

  function automatic bit exp_accept(input logic [1:0] m, input bit aw, input bit en,
                                    input bit busy, input logic [W-1:0] d,
                                    input bit b9, input logic [W-1:0] a);
    bit nine = m[1];
    if (!en || busy) return 1'b0;
    if (!nine || !aw) return 1'b1;
    return b9 && (d == a);
  endfunction

  function automatic string tag_of(input logic [1:0] m, input bit aw, input bit en,
                                   input bit busy, input bit b9, input bit acc);
    if (!en) return "R5";
    if (busy) return "R8";
    if (!m[1]) return "R9";
    if (!aw) return "R4";
    if (!acc) return b9 ? "R3/R6" : "R3";
    return "R2";
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (rx_flag !== m_flag || rx_data !== m_data || rx_bit9 !== m_bit9) begin
      failures++;
      $display("FAIL %s: got flag=%0b data=%02h bit9=%0b expected flag=%0b data=%02h bit9=%0b",
               tag, rx_flag, rx_data, rx_bit9, m_flag, m_data, m_bit9);
    end
  endtask

  task automatic step(input logic [1:0] m, input bit aw, input bit en, input bit fv,
                      input logic [W-1:0] d, input bit b9, input bit clr,
                      input string force_tag);
    bit acc;
    string t;
    @(negedge clk);
    mode_sel = m; addr_wait_en = aw; rx_enable = en; frame_valid = fv;
    frame_data = d; frame_bit9 = b9; flag_clr = clr;
    acc = fv && exp_accept(m, aw, en, m_flag, d, b9, node_addr);
    t = (force_tag != "") ? force_tag :
        (!fv ? (clr ? "R7" : "R7") : tag_of(m, aw, en, m_flag, b9, acc));
    if (acc) begin
      m_flag = 1'b1; m_data = d; m_bit9 = b9;
    end else if (clr) begin
      m_flag = 1'b0;
    end
    @(negedge clk);
    frame_valid = 1'b0; flag_clr = 1'b0;
    check_out(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    node_addr = 8'h5A;
    repeat (3) @(negedge clk);
    check_out("R1");
    @(negedge clk); rst = 1'b0;
    check_out("R1");

    // R2 own address accepted (R10: visible at next cycle)
    step(2'd2, 1, 1, 1, 8'h5A, 1, 0, "R10");
    step(2'd2, 1, 1, 0, 8'h00, 0, 1, "R7");
    // R3 matching byte with ninth bit 0 rejected
    step(2'd3, 1, 1, 1, 8'h5A, 0, 0, "R3");
    // R3/R6 other address rejected, registers unchanged
    step(2'd3, 1, 1, 1, 8'h33, 1, 0, "R6");
    // R4 data byte accepted with address-wait off
    step(2'd3, 0, 1, 1, 8'hC3, 0, 0, "R4");
    // R8 frame while flag set dropped
    step(2'd3, 0, 1, 1, 8'h11, 1, 0, "R8");
    // R7 flag remains without clear, then clears
    step(2'd3, 0, 1, 0, 8'h00, 0, 0, "R7");
    step(2'd3, 0, 1, 0, 8'h00, 0, 1, "R7");
    // R7 accept wins over same-cycle clear
    step(2'd2, 0, 1, 1, 8'h77, 1, 1, "R7");
    step(2'd2, 0, 1, 0, 8'h00, 0, 1, "R7");
    // R5 disabled receiver
    step(2'd2, 0, 0, 1, 8'h99, 1, 0, "R5");
    step(2'd1, 1, 0, 1, 8'h5A, 1, 0, "R5");
    // R9 eight-bit mode bypasses filter, stop bit captured
    step(2'd1, 1, 1, 1, 8'h12, 1, 0, "R9");
    step(2'd1, 1, 1, 0, 8'h00, 0, 1, "R7");
    step(2'd0, 1, 1, 1, 8'h34, 0, 0, "R9");
    step(2'd0, 1, 1, 0, 8'h00, 0, 1, "R7");

    for (int i = 0; i < 400; i++) begin
      logic [1:0]   m  = 2'($urandom_range(0, 3));
      bit           aw = 1'($urandom_range(0, 1));
      bit           en = ($urandom_range(0, 7) != 0);
      bit           fv = ($urandom_range(0, 4) != 0);
      logic [W-1:0] d  = ($urandom_range(0, 2) == 0) ? node_addr : 8'($urandom);
      bit           b9 = 1'($urandom_range(0, 1));
      bit           cl = ($urandom_range(0, 2) == 0);
      if (i % 50 == 0) node_addr = 8'($urandom);
      step(m, aw, en, fv, d, b9, cl, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule